// File: doc/BRIEF.md
# Battery Supply Fault Monitor

This block watches two comparator outputs on the battery supply, one that goes high when the supply is too low and one that goes high when it is too high. Both arrive without any relation to the system clock. The block passes each one through a two-flop synchronizer into the single clock domain. Each then goes through its own minimum-duration filter, whose length is a cycle count set at the ports. A short glitch on a comparator output is therefore never reported.

Each filter drives a qualified output. A sticky fault flag records that either condition became qualified. The flag holds until the clear strobe is pulsed. While the active-low power-on reset is held, every flop is cleared and the flag records nothing, whatever the comparators do. The block sits between the analog front end and whatever logic reads or acts on the fault status.

Top module: `batt_fault_monitor`

## Requirements
- R1: While rst_n is low, uv_qual, ov_qual and fault_flag are 0 whatever uv_raw and ov_raw do. Asserting rst_n low clears a set fault_flag at once.
- R2: Each raw input reaches the logic through exactly two flip-flops. With a filter length of 0, a rise on the raw input held stable before a rising edge shows on its qualified output after exactly two rising edges.
- R3: uv_qual rises 2 + uv_len rising edges after uv_raw goes high, provided uv_raw stays high that long. It then stays high while the synchronized input stays high, so a pulse of W edges gives W − uv_len high cycles when W > uv_len and none otherwise.
- R4: ov_qual follows the same rule with ov_len. It is timed independently of the undervoltage path and of uv_len.
- R5: A low synchronized input drops the qualified output in the same cycle and restarts the count from zero. A high pulse shorter than or equal to the length never qualifies.
- R6: A length of 0 makes the qualified output equal the synchronized input, with no added delay.
- R7: fault_flag goes to 1 on the rising edge after a 0→1 change of either qualified output.
- R8: fault_flag stays 1 until flag_clr is high at a rising edge, and it then reads 0 after that edge.
- R9: When flag_clr is high in the same cycle as a new qualified rise, the set wins and fault_flag is 1.
- R10: A qualified output that simply stays high does not set fault_flag again after a clear. Only a new 0→1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| uv_raw | input | 1 | Asynchronous undervoltage comparator output |
| ov_raw | input | 1 | Asynchronous overvoltage comparator output |
| uv_len | input | 16 | Undervoltage qualification length in clock cycles |
| ov_len | input | 16 | Overvoltage qualification length in clock cycles |
| flag_clr | input | 1 | Clear strobe for the sticky fault flag |
| fault_flag | output | 1 | Sticky record of any qualified fault |
| uv_qual | output | 1 | Qualified undervoltage condition |
| ov_qual | output | 1 | Qualified overvoltage condition |

## Verification
The synchronizer check compares the second stage with the raw value from two edges before. It therefore assumes the raw inputs are stable around each rising edge, which a real comparator does not guarantee. The bench respects this by changing the raw inputs only on the falling edge. The hold and early-qualification checks assume the length inputs stay constant while a pulse is being counted. The bench changes a length only while both raw inputs and both counters are at rest. Flag checks assume flag_clr is a synchronous level, and the bench drives it as a one-cycle pulse between edges.

// File: rtl/batmon_pkg.sv
package batmon_pkg;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 2;
  localparam int CH_UV  = 0;
  localparam int CH_OV  = 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // Count one more high cycle, holding at the top value.
  function automatic cnt_t sat_inc(input cnt_t c);
    if (c == {CNT_W{1'b1}}) return c;
    return c + cnt_t'(1);
  endfunction

  // The input has been high long enough once the count reaches the length.
  function automatic logic len_met(input cnt_t c, input cnt_t len);
    return (c >= len);
  endfunction
endpackage

// File: rtl/batmon_sync.sv
module batmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= raw_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_TWO_FLOP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_o == $past(raw_i, 2))); // R2
    end
  endgenerate
endmodule

// File: rtl/batmon_filter.sv
module batmon_filter
  import batmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  cnt_t len_i,
  output logic qual_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt_q <= '0;
    else if (!level_i) cnt_q <= '0;
    else               cnt_q <= sat_inc(cnt_q);

  assign qual_o = level_i && len_met(cnt_q, len_i);

  AST_QUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |=> (qual_o || !level_i || (len_i != $past(len_i)))); // R3
  AST_NO_EARLY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && (len_i != '0)) |-> $past(level_i)); // R5
  AST_LOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |-> !qual_o); // R5
  AST_ZERO_LEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i == '0) |-> (qual_o == level_i)); // R6
endmodule

// File: rtl/batmon_flag.sv
module batmon_flag #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] qual_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              set_evt_o
);
  logic [NUM_CH-1:0] qual_d;
  logic [NUM_CH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) qual_d <= '0;
    else        qual_d <= qual_i;

  assign rise      = qual_i & ~qual_d;
  assign set_evt_o = |rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag_o <= 1'b0;
    else if (set_evt_o) flag_o <= 1'b1;
    else if (clr_i)     flag_o <= 1'b0;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt_o |=> flag_o); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_evt_o) |=> !flag_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R8
  AST_FLAG_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_evt_o)); // R10
endmodule

// File: rtl/batt_fault_monitor.sv
module batt_fault_monitor
  import batmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_raw,
  input  logic             ov_raw,
  input  logic [CNT_W-1:0] uv_len,
  input  logic [CNT_W-1:0] ov_len,
  input  logic             flag_clr,
  output logic             fault_flag,
  output logic             uv_qual,
  output logic             ov_qual
);
  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] sync_vec;
  logic [NUM_CH-1:0] qual_vec;
  cnt_t              len_vec [NUM_CH];
  logic              set_evt;

  assign raw_vec[CH_UV] = uv_raw;
  assign raw_vec[CH_OV] = ov_raw;
  assign len_vec[CH_UV] = uv_len;
  assign len_vec[CH_OV] = ov_len;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      batmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_vec[c]),
        .sync_o (sync_vec[c])
      );
      batmon_filter u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_vec[c]),
        .len_i   (len_vec[c]),
        .qual_o  (qual_vec[c])
      );
    end
  endgenerate

  batmon_flag #(.NUM_CH(NUM_CH)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual_i    (qual_vec),
    .clr_i     (flag_clr),
    .flag_o    (fault_flag),
    .set_evt_o (set_evt)
  );

  assign uv_qual = qual_vec[CH_UV];
  assign ov_qual = qual_vec[CH_OV];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!fault_flag && !uv_qual && !ov_qual)); // R1
  AST_PATHS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_qual && !$past(uv_qual) && !ov_raw && !$past(ov_raw) && !$past(ov_raw, 2))
      |-> !ov_qual); // R4
endmodule

// File: tb/batt_fault_monitor_test.sv
`timescale 1ns/1ps
module batt_fault_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uv_raw = 1'b0, ov_raw = 1'b0, flag_clr = 1'b0;
  logic [15:0] uv_len = '0, ov_len = '0;
  logic        fault_flag, uv_qual, ov_qual;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  batt_fault_monitor uut (
    .clk(clk), .rst_n(rst_n), .uv_raw(uv_raw), .ov_raw(ov_raw),
    .uv_len(uv_len), .ov_len(ov_len), .flag_clr(flag_clr),
    .fault_flag(fault_flag), .uv_qual(uv_qual), .ov_qual(ov_qual)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected number of high cycles of the qualified output for a pulse of w edges.
  function automatic int exp_hits(input int w, input int l);
    return (w > l) ? (w - l) : 0;
  endfunction

  function automatic int exp_first(input int w, input int l);
    return (w > l) ? (2 + l) : -1;
  endfunction

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic run_trial(input int ch, input int l, input int w);
    int first = -1;
    int hits = 0;
    int other = 0;
    int q;
    if (ch == 0) uv_len = 16'(l); else ov_len = 16'(l);
    if (ch == 0) ov_len = 16'(l + 3); else uv_len = 16'(l + 3);
    if (ch == 0) uv_raw = 1'b1; else ov_raw = 1'b1;
    for (int i = 1; i <= w + l + 6; i++) begin
      @(negedge clk);
      q = (ch == 0) ? int'(uv_qual) : int'(ov_qual);
      other += (ch == 0) ? int'(ov_qual) : int'(uv_qual);
      if (q != 0) begin
        hits++;
        if (first < 0) first = i;
      end
      if (w > l && i == 2 + l) check("R7 flag before set", int'(fault_flag), 0);
      if (w > l && i == 3 + l) check("R7 flag after rise", int'(fault_flag), 1);
      if (i == w) begin
        if (ch == 0) uv_raw = 1'b0; else ov_raw = 1'b0;
      end
    end
    if (ch == 0) begin
      check("R3 uv first edge", first, exp_first(w, l));
      check("R3 R5 uv high cycles", hits, exp_hits(w, l));
    end else begin
      check("R4 ov first edge", first, exp_first(w, l));
      check("R4 R5 ov high cycles", hits, exp_hits(w, l));
    end
    check("R4 other path quiet", other, 0);
    check("R8 flag held after pulse", int'(fault_flag), (w > l) ? 1 : 0);
    pulse_clr();
    check("R8 flag cleared", int'(fault_flag), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R1: raw inputs active during reset
    uv_raw = 1'b1; ov_raw = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 uv_qual in reset", int'(uv_qual), 0);
    check("R1 ov_qual in reset", int'(ov_qual), 0);
    check("R1 flag in reset", int'(fault_flag), 0);
    uv_raw = 1'b0; ov_raw = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flag after release", int'(fault_flag), 0);

    // R2 and R6: length zero, two-edge latency
    uv_len = 0;
    uv_raw = 1'b1;
    @(negedge clk);
    check("R2 one edge not yet", int'(uv_qual), 0);
    @(negedge clk);
    check("R2 R6 two edges", int'(uv_qual), 1);
    uv_raw = 1'b0;
    @(negedge clk);
    check("R6 still follows", int'(uv_qual), 1);
    @(negedge clk);
    check("R6 drops with input", int'(uv_qual), 0);
    repeat (3) @(negedge clk);
    pulse_clr();

    // Sweep lengths and pulse widths on both paths (R3 R4 R5 R6 R7 R8)
    for (int ch = 0; ch < 2; ch++)
      for (int l = 0; l <= 6; l++)
        for (int w = 1; w <= 9; w++)
          run_trial(ch, l, w);

    // R4: both together, different lengths
    uv_len = 3; ov_len = 7;
    uv_raw = 1'b1; ov_raw = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      check("R4 uv independent", int'(uv_qual), (i >= 5) ? 1 : 0);
      check("R4 ov independent", int'(ov_qual), (i >= 9) ? 1 : 0);
    end

    // R10: hold uv qualified, clear, no re-set
    ov_raw = 1'b0;
    repeat (3) @(negedge clk);
    pulse_clr();
    repeat (4) @(negedge clk);
    check("R10 level does not re-set", int'(fault_flag), 0);
    check("R10 uv still qualified", int'(uv_qual), 1);
    ov_len = 0;
    ov_raw = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 ov rise seen", int'(ov_qual), 1);
    @(negedge clk);
    check("R10 new rise sets", int'(fault_flag), 1);
    uv_raw = 1'b0; ov_raw = 1'b0;
    repeat (4) @(negedge clk);
    pulse_clr();
    check("R8 cleared before R9", int'(fault_flag), 0);

    // R9: clear and set in the same cycle
    uv_len = 0;
    uv_raw = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 rise present", int'(uv_qual), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R9 set wins over clear", int'(fault_flag), 1);
    uv_raw = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset mid-run clears a set flag at once
    check("R1 flag set before reset", int'(fault_flag), 1);
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R1 async clear of flag", int'(fault_flag), 0);
    uv_raw = 1'b1; ov_raw = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 no record in reset", int'(fault_flag), 0);
    check("R1 uv quiet in reset", int'(uv_qual), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule